// File: doc/BRIEF.md
# Cell Voltage Fault Sequencer

This block decides, from cell-voltage comparator results taken on a slow time base, when the series power switch of a single-cell lithium pack must be opened for overcharge or overdischarge, and when it may close again. A free-running tick is divided by a prescaler into a quarter period (nominally 0.25 s). Four quarters make the normal sample period (nominally 1 s). At each sample instant the block reads four level flags: above the safe limit, above the maximum, above the maximum less hysteresis, and below the minimum. It then updates one consecutive-run counter for each direction.

Overcharge and overdischarge each have their own filter, latch and recovery rule. While overcharge is latched, a cell-bypass enable and a full flag are raised. A load seen in that state lets the switch conduct only in an active-rectification mode, and only while the load remains. A clear pulse from the enable logic wipes all sample history and requests the gate on again.

Top module: `cellVoltageSequencer`

## Requirements
- R1: After reset or a clear pulse, with no over-maximum reading, a sample strobe occurs once every 4*TICK_DIV ticks.
- R2: After one sample with the above-maximum flag set, the strobe spacing becomes TICK_DIV ticks.
- R3: The spacing returns to 4*TICK_DIV ticks only after four consecutive samples below the maximum. After three such samples the next strobe is still TICK_DIV ticks later.
- R4: Four consecutive samples above the maximum drop gateEn (0) in the cycle after the fourth sample. Three do not. A sample that breaks the run restarts the count from zero.
- R5: One sample with the above-safe flag set drops gateEn in the cycle after that sample.
- R6: Four consecutive samples with the below-minimum flag set drop gateEn. A sample that breaks the run restarts the count.
- R7: From the overdischarge latch, chargerDet=1 raises gateEn within two clocks, with no sample needed. From the overcharge latch, chargerDet has no effect on gateEn.
- R8: bypassEn and fullFlag are both 1 from the sample that latches overcharge. Both return to 0 after the first later sample with the above-maximum flag clear.
- R9: While overcharge is latched, gateEn and activeRect equal loadDet, following it in the same cycle.
- R10: From the overcharge latch, full conduction (gateEn=1 with activeRect=0 and loadDet=0) returns after one sample with the above-hysteresis flag clear. It also returns after four consecutive samples below the maximum, and not after three.
- R11: A clear pulse sets gateEn=1, bypassEn=0 and fullFlag=0 in the next cycle from any state, and erases every run counter.
- R12: During and right after reset, gateEn=1 and activeRect, bypassEn and fullFlag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Free-running time-base tick, one-cycle pulses or held high |
| cellAboveSafe | input | 1 | Cell above maximum plus safety margin |
| cellAboveMax | input | 1 | Cell above the maximum limit |
| cellAboveHyst | input | 1 | Cell above maximum less hysteresis |
| cellBelowMin | input | 1 | Cell below the minimum limit |
| loadDet | input | 1 | Load detected at the pack |
| chargerDet | input | 1 | Charger detected at the pack |
| clearPulse | input | 1 | One-cycle history clear from the enable logic |
| gateEn | output | 1 | Request to turn the power switch on |
| activeRect | output | 1 | Switch conducting in active-rectification mode |
| bypassEn | output | 1 | Cell-bypass load enable |
| fullFlag | output | 1 | Overcharge indication |
| sampleStrobe | output | 1 | High in the cycle a sample is taken |

## Verification
The properties assume the comparator flags are nested consistently: above-safe implies above-maximum, above-maximum implies above-hysteresis, and below-minimum excludes above-hysteresis. They also assume a clear pulse lasts one cycle. The bench drives the flags only through a level task that maps a single cell level onto all four flags, which keeps the nesting by construction. It changes inputs only just after a clock edge and never in a cycle that carries a sample strobe, and each clear pulse it drives lasts exactly one cycle.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_OVER  = 2'd1,
    MODE_UNDER = 2'd2
  } seqMode_e;

  // counter index map for the run counters
  localparam int RUN_OVER  = 0;
  localparam int RUN_BELOW = 1;
  localparam int RUN_UNDER = 2;
  localparam int RUN_NUM   = 3;

  typedef struct packed {
    logic               clrAll;
    logic [RUN_NUM-1:0] runInc;
    logic [RUN_NUM-1:0] runClr;
    logic               setFast;
    logic               clrFast;
  } runCmd_t;

endpackage

// File: rtl/cvs_datapath.sv
module cvs_datapath
  import cvs_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int QUARTERS = 4,
  parameter int RUN_LEN  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  runCmd_t            cmd,
  output logic               sampleStrobe,
  output logic               fastMode,
  output logic [RUN_NUM-1:0] runNearEnd
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int Q_W   = (QUARTERS > 1) ? $clog2(QUARTERS) : 1;
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [Q_W-1:0]   Q_LAST   = Q_W'(QUARTERS - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [PRE_W-1:0] preCnt;
  logic [Q_W-1:0]   quarterCnt;
  logic             fastQ;
  logic             quarterEnd;

  assign quarterEnd   = tick && (preCnt == PRE_LAST);
  assign sampleStrobe = quarterEnd && (fastQ || (quarterCnt == Q_LAST));
  assign fastMode     = fastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      quarterCnt <= '0;
    end else if (cmd.clrAll) begin
      preCnt     <= '0;
      quarterCnt <= '0;
    end else if (tick) begin
      preCnt <= quarterEnd ? '0 : preCnt + 1'b1;
      if (quarterEnd) begin
        quarterCnt <= (quarterCnt == Q_LAST) ? '0 : quarterCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastQ <= 1'b0;
    end else if (cmd.clrAll) begin
      fastQ <= 1'b0;
    end else if (cmd.setFast) begin
      fastQ <= 1'b1;
    end else if (cmd.clrFast) begin
      fastQ <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < RUN_NUM; gi++) begin : gRun
    logic [RUN_W-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (cmd.clrAll || cmd.runClr[gi]) begin
        runCnt <= '0;
      end else if (cmd.runInc[gi]) begin
        runCnt <= runCnt + 1'b1;
      end
    end
    assign runNearEnd[gi] = (runCnt == RUN_LAST);
  end

endmodule

// File: rtl/cvs_control.sv
module cvs_control
  import cvs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStrobe,
  input  logic               fastMode,
  input  logic [RUN_NUM-1:0] runNearEnd,
  input  logic               cellAboveSafe,
  input  logic               cellAboveMax,
  input  logic               cellAboveHyst,
  input  logic               cellBelowMin,
  input  logic               loadDet,
  input  logic               chargerDet,
  input  logic               clearPulse,
  output runCmd_t            cmd,
  output logic               gateEn,
  output logic               activeRect,
  output logic               bypassEn
);

  seqMode_e mode, nextMode;
  logic     bypassOn, nextBypass;

  always_comb begin
    cmd        = '0;
    cmd.clrAll = clearPulse;
    nextMode   = mode;
    nextBypass = bypassOn;
    if (clearPulse) begin
      nextMode   = MODE_RUN;
      nextBypass = 1'b0;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (sampleStrobe) begin
            if (cellAboveSafe) begin
              nextMode   = MODE_OVER;
              nextBypass = 1'b1;
              cmd.setFast = 1'b1;
              cmd.runClr  = '1;
            end else if (cellAboveMax) begin
              cmd.setFast = 1'b1;
              cmd.runClr[RUN_BELOW] = 1'b1;
              cmd.runClr[RUN_UNDER] = 1'b1;
              if (runNearEnd[RUN_OVER]) begin
                nextMode   = MODE_OVER;
                nextBypass = 1'b1;
                cmd.runClr[RUN_OVER] = 1'b1;
              end else begin
                cmd.runInc[RUN_OVER] = 1'b1;
              end
            end else begin
              cmd.runClr[RUN_OVER] = 1'b1;
              if (fastMode) begin
                if (runNearEnd[RUN_BELOW]) begin
                  cmd.clrFast = 1'b1;
                  cmd.runClr[RUN_BELOW] = 1'b1;
                end else begin
                  cmd.runInc[RUN_BELOW] = 1'b1;
                end
              end
              if (cellBelowMin) begin
                if (runNearEnd[RUN_UNDER]) begin
                  nextMode = MODE_UNDER;
                  cmd.runClr[RUN_UNDER] = 1'b1;
                end else begin
                  cmd.runInc[RUN_UNDER] = 1'b1;
                end
              end else begin
                cmd.runClr[RUN_UNDER] = 1'b1;
              end
            end
          end
        end
        MODE_OVER: begin
          if (sampleStrobe) begin
            if (cellAboveMax) begin
              nextBypass = 1'b1;
              cmd.runClr[RUN_BELOW] = 1'b1;
            end else begin
              nextBypass = 1'b0;
              if (runNearEnd[RUN_BELOW]) begin
                nextMode    = MODE_RUN;
                cmd.clrFast = 1'b1;
                cmd.runClr[RUN_BELOW] = 1'b1;
              end else begin
                cmd.runInc[RUN_BELOW] = 1'b1;
                if (!cellAboveHyst) begin
                  nextMode = MODE_RUN;
                end
              end
            end
          end
        end
        MODE_UNDER: begin
          if (chargerDet) begin
            nextMode = MODE_RUN;
            cmd.runClr[RUN_UNDER] = 1'b1;
          end
        end
        default: nextMode = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_RUN;
      bypassOn <= 1'b0;
    end else begin
      mode     <= nextMode;
      bypassOn <= nextBypass;
    end
  end

  assign activeRect = (mode == MODE_OVER) && loadDet;
  assign gateEn     = (mode == MODE_RUN) || activeRect;
  assign bypassEn   = bypassOn;

endmodule

// File: rtl/cellVoltageSequencer.sv
module cellVoltageSequencer
  import cvs_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int QUARTERS = 4,
  parameter int RUN_LEN  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic cellAboveSafe,
  input  logic cellAboveMax,
  input  logic cellAboveHyst,
  input  logic cellBelowMin,
  input  logic loadDet,
  input  logic chargerDet,
  input  logic clearPulse,
  output logic gateEn,
  output logic activeRect,
  output logic bypassEn,
  output logic fullFlag,
  output logic sampleStrobe
);

  runCmd_t            cmd;
  logic               fastMode;
  logic [RUN_NUM-1:0] runNearEnd;

  cvs_datapath #(
    .TICK_DIV(TICK_DIV),
    .QUARTERS(QUARTERS),
    .RUN_LEN (RUN_LEN)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .cmd         (cmd),
    .sampleStrobe(sampleStrobe),
    .fastMode    (fastMode),
    .runNearEnd  (runNearEnd)
  );

  cvs_control uControl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .fastMode     (fastMode),
    .runNearEnd   (runNearEnd),
    .cellAboveSafe(cellAboveSafe),
    .cellAboveMax (cellAboveMax),
    .cellAboveHyst(cellAboveHyst),
    .cellBelowMin (cellBelowMin),
    .loadDet      (loadDet),
    .chargerDet   (chargerDet),
    .clearPulse   (clearPulse),
    .cmd          (cmd),
    .gateEn       (gateEn),
    .activeRect   (activeRect),
    .bypassEn     (bypassEn)
  );

  assign fullFlag = bypassEn;

endmodule

// File: rtl/cvs_checker.sv
module cvs_checker (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic cellAboveSafe,
  input logic cellAboveMax,
  input logic loadDet,
  input logic chargerDet,
  input logic clearPulse,
  input logic gateEn,
  input logic activeRect,
  input logic bypassEn,
  input logic fullFlag,
  input logic sampleStrobe
);

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> tick); // R1

  AST_SAFE_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && cellAboveSafe && gateEn && !activeRect && !clearPulse)
    |=> (bypassEn && fullFlag && (gateEn == activeRect))); // R5

  AST_BYPASS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !cellAboveMax && !clearPulse) |=> (!bypassEn && !fullFlag)); // R8

  AST_RECT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    activeRect |-> (loadDet && gateEn && bypassEn == fullFlag)); // R9

  AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> (gateEn && !bypassEn && !fullFlag)); // R11

  AST_GATE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateEn) |-> ($past(clearPulse) || $past(sampleStrobe) || $past(chargerDet) || loadDet)); // R7

endmodule

bind cellVoltageSequencer cvs_checker uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .tick         (tick),
  .cellAboveSafe(cellAboveSafe),
  .cellAboveMax (cellAboveMax),
  .loadDet      (loadDet),
  .chargerDet   (chargerDet),
  .clearPulse   (clearPulse),
  .gateEn       (gateEn),
  .activeRect   (activeRect),
  .bypassEn     (bypassEn),
  .fullFlag     (fullFlag),
  .sampleStrobe (sampleStrobe)
);

// File: tb/tb_cellVoltageSequencer.sv
`timescale 1ns/1ps
module tb_cellVoltageSequencer;

  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic cellAboveSafe = 1'b0, cellAboveMax = 1'b0, cellAboveHyst = 1'b0, cellBelowMin = 1'b0;
  logic loadDet = 1'b0, chargerDet = 1'b0, clearPulse = 1'b0;
  logic gateEn, activeRect, bypassEn, fullFlag, sampleStrobe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cellVoltageSequencer #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cellAboveSafe(cellAboveSafe), .cellAboveMax(cellAboveMax),
    .cellAboveHyst(cellAboveHyst), .cellBelowMin(cellBelowMin),
    .loadDet(loadDet), .chargerDet(chargerDet), .clearPulse(clearPulse),
    .gateEn(gateEn), .activeRect(activeRect), .bypassEn(bypassEn),
    .fullFlag(fullFlag), .sampleStrobe(sampleStrobe)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 below min, 1 mid band, 2 between hysteresis and max, 3 above max, 4 above safe
  task automatic setLevel(int lvl);
    cellBelowMin  = (lvl == 0);
    cellAboveHyst = (lvl >= 2);
    cellAboveMax  = (lvl >= 3);
    cellAboveSafe = (lvl >= 4);
  endtask

  task automatic runSamples(int n);
    for (int i = 0; i < n; i++) begin
      do begin @(negedge clk); #1; end while (!sampleStrobe);
      @(posedge clk); #1;
    end
  endtask

  task automatic measureGap(output int gap);
    do begin @(negedge clk); #1; end while (!sampleStrobe);
    @(posedge clk);
    gap = 0;
    do begin @(negedge clk); #1; gap++; end while (!sampleStrobe);
    @(posedge clk); #1;
  endtask

  task automatic pulseClear();
    @(negedge clk); clearPulse = 1'b1;
    @(negedge clk); clearPulse = 1'b0;
    #1;
  endtask

  task automatic testReset();
    check("R12 gateEn", gateEn, 1);
    check("R12 activeRect", activeRect, 0);
    check("R12 bypassEn", bypassEn, 0);
    check("R12 fullFlag", fullFlag, 0);
  endtask

  task automatic testRates();
    int gap;
    pulseClear();
    setLevel(1);
    measureGap(gap);
    check("R1 slow spacing", gap, 4*DIV);
    setLevel(3);
    runSamples(1);
    setLevel(1);
    measureGap(gap);
    check("R2 fast spacing", gap, DIV);
    measureGap(gap);
    check("R3 three below keeps fast", gap, DIV);
    measureGap(gap);
    check("R3 four below restores slow", gap, 4*DIV);
    check("R3 gate stays on", gateEn, 1);
  endtask

  task automatic testOvercharge();
    pulseClear();
    setLevel(3);
    runSamples(2);
    setLevel(2);
    runSamples(1);
    setLevel(3);
    runSamples(3);
    check("R4 broken run restarts", gateEn, 1);
    runSamples(1);
    check("R4 four over drops gate", gateEn, 0);
    check("R8 bypass set", bypassEn, 1);
    check("R8 full set", fullFlag, 1);
    setLevel(2);
    runSamples(1);
    check("R8 bypass cleared", bypassEn, 0);
    check("R8 full cleared", fullFlag, 0);
    check("R10 one below max not enough", gateEn, 0);
    runSamples(2);
    check("R10 three below max not enough", gateEn, 0);
    runSamples(1);
    check("R10 four below max restore", gateEn, 1);
    check("R10 full drive", activeRect, 0);
  endtask

  task automatic testSafeAndLoad();
    pulseClear();
    setLevel(4);
    runSamples(1);
    check("R5 safe trip gate", gateEn, 0);
    check("R5 safe trip bypass", bypassEn, 1);
    loadDet = 1'b1; #1;
    check("R9 load gate", gateEn, 1);
    check("R9 load rect", activeRect, 1);
    @(negedge clk); loadDet = 1'b0; #1;
    check("R9 load removed gate", gateEn, 0);
    check("R9 load removed rect", activeRect, 0);
    chargerDet = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check("R7 charger ignored in overcharge", gateEn, 0);
    chargerDet = 1'b0;
    setLevel(1);
    runSamples(1);
    check("R10 hysteresis recovery", gateEn, 1);
    check("R10 hysteresis no rect", activeRect, 0);
  endtask

  task automatic testUnder();
    pulseClear();
    setLevel(0);
    runSamples(3);
    setLevel(1);
    runSamples(1);
    setLevel(0);
    runSamples(3);
    check("R6 broken run restarts", gateEn, 1);
    runSamples(1);
    check("R6 four under drops gate", gateEn, 0);
    check("R6 no bypass", bypassEn, 0);
    @(negedge clk); chargerDet = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R7 charger recovers", gateEn, 1);
    chargerDet = 1'b0;
  endtask

  task automatic testClear();
    pulseClear();
    setLevel(3);
    runSamples(3);
    pulseClear();
    check("R11 gate after clear", gateEn, 1);
    runSamples(1);
    check("R11 history erased", gateEn, 1);
    runSamples(3);
    check("R11 normal count after clear", gateEn, 0);
    pulseClear();
    check("R11 clear from overcharge gate", gateEn, 1);
    check("R11 clear from overcharge bypass", bypassEn, 0);
    setLevel(0);
    runSamples(4);
    check("R11 under latched", gateEn, 0);
    pulseClear();
    check("R11 clear from under", gateEn, 1);
    setLevel(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    setLevel(1);
    repeat (3) @(negedge clk);
    #1;
    testReset();
    @(negedge clk); rstN = 1'b1; tick = 1'b1;
    #1;
    testReset();
    testRates();
    testOvercharge();
    testSafeAndLoad();
    testUnder();
    testClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule